// File: doc/BRIEF.md
# Lamp Ballast Mode Sequencer

This block is the mode controller of an electronic fluorescent-lamp ballast. It takes the outputs of the analog comparators as single-bit flags and steps the ballast through its modes: power-off lockout, filament preheat, ignition, pre-run, run and a latched fault. Its outputs enable the half-bridge oscillator and command the discharge switches on the timing capacitor and on the VCO node. A separate output holds the gate drivers off while a fault is latched. The comparators, the oscillator and the drivers are outside the block.

The timing capacitor sets the sequence. Preheat ends when the capacitor first reaches two thirds of supply. The capacitor is then dumped to one third and ramps again. Ignition ends at one half, and pre-run ends at the second two-thirds crossing.

Each mode treats current-sense over-threshold cycles in its own way:
- Preheat and run feed them into an up/down event counter.
- Ignition turns each one into a short VCO discharge pulse, which raises the frequency.
- Pre-run trips on the first one.

An end-of-life window violation counts only in run. It must persist for a programmable number of low-side cycles before the block trips.

Every flag passes through a two-flop synchronizer. The mode is one-hot and is brought out on a port.

Top module: `ballast_seq`

## Requirements
- R1: After reset `mode_o` is lockout (6'b000001), `osc_en_o`=0, `cap_dump_o`=1, `vco_dump_o`=1 and `gate_off_o`=0.
- R2: Lockout is left for preheat only when three conditions hold in the same clock: `vcc_on_i`=1, `bus_en_i`=1, and `eol_hi_i`=0 (pin below its 3 V level). `bus_dis_i`, `vcc_off_i` and `sd_hi_i` must also be 0. In preheat `osc_en_o`=1 and both dump outputs are 0.
- R3: In preheat, the first `cap_two3_i` crossing asserts `cap_dump_o`. The block stays in preheat until `cap_third_i` falls to 0, and then enters ignition with `cap_dump_o` released. A later rise of `cap_third_i` does not re-assert `cap_dump_o`.
- R4: Ignition moves to pre-run when `cap_half_i`=1. Pre-run moves to run when `cap_two3_i`=1.
- R5: In ignition, a low-side cycle with `cs_over_i`=1 produces a one-clock pulse on `vco_dump_o` and never leads to fault.
- R6: In pre-run, a single low-side cycle with `cs_over_i`=1 enters fault.
- R7: In preheat and run, a counter is incremented on each low-side cycle with over-current and decremented (floor 0) on each cycle without. Fault is entered when the counter reaches OC_LIMIT (default 60). Alternating cycles never trip, 59 consecutive cycles from zero do not trip, and the 60th does.
- R8: In run, a window violation (`eol_hi_i` or `eol_lo_i`) held for EOL_LIMIT (default 60) consecutive low-side cycles enters fault. One clean cycle restarts the count. Violations in any other mode have no effect.
- R9: In fault, `gate_off_o`=1, `osc_en_o`=0, and both dump outputs are 1. Fault holds through `bus_dis_i` and is left for lockout only on `vcc_off_i` or `sd_hi_i`.
- R10: From any active mode, `vcc_off_i`, `sd_hi_i` or `bus_dis_i` returns the block to lockout. This exit wins over any other transition in the same clock.
- R11: After an exit to lockout, the sequence restarts from preheat once the R2 conditions return.
- R12: A flag change driven just after a clock edge is not visible on `mode_o` after two rising edges and is visible after the third.
- R13: The `mode_o` bits are: bit0 lockout, bit1 preheat, bit2 ignition, bit3 pre-run, bit4 run, bit5 fault. Exactly one bit is set.
- R14: A low-side cycle is counted on each rising edge of the synchronized `lo_i`. `cs_over_i` and the window flags are sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vcc_on_i | input | 1 | Supply above rising threshold |
| vcc_off_i | input | 1 | Supply below falling threshold |
| bus_en_i | input | 1 | DC bus above enable level |
| bus_dis_i | input | 1 | DC bus below disable level |
| sd_hi_i | input | 1 | Shutdown pin above 5 V |
| eol_hi_i | input | 1 | Shutdown/window pin above 3 V |
| eol_lo_i | input | 1 | Window pin below 1 V |
| cap_third_i | input | 1 | Timing capacitor above 1/3 supply |
| cap_half_i | input | 1 | Timing capacitor above 1/2 supply |
| cap_two3_i | input | 1 | Timing capacitor above 2/3 supply |
| cs_over_i | input | 1 | Current sense above threshold |
| lo_i | input | 1 | Low-side gate level, one rise per cycle |
| mode_o | output | 6 | One-hot mode |
| osc_en_o | output | 1 | Oscillator enable |
| cap_dump_o | output | 1 | Timing capacitor discharge |
| vco_dump_o | output | 1 | VCO node discharge |
| gate_off_o | output | 1 | Gate outputs latched low |

## Verification
A supply, shutdown or bus exit can arrive in the same clock as a capacitor crossing that would advance the mode, for example pre-run reaching two thirds. The bench provokes this by changing both raw flags at one falling edge, so that they leave the synchronizer together. It then requires lockout on `mode_o` and not run. It also places the last step of each event count exactly at the limit boundary, so that the trip cycle and the cycle before it are both judged.

// File: rtl/ballast_pkg.sv
package ballast_pkg;

    typedef enum logic [5:0] {
        MD_OFF     = 6'b000001,
        MD_PREHEAT = 6'b000010,
        MD_IGNITE  = 6'b000100,
        MD_PRERUN  = 6'b001000,
        MD_RUN     = 6'b010000,
        MD_FAULT   = 6'b100000
    } mode_e;

    typedef struct packed {
        logic vcc_on;
        logic vcc_off;
        logic bus_en;
        logic bus_dis;
        logic sd_hi;
        logic eol_hi;
        logic eol_lo;
        logic cap_third;
        logic cap_half;
        logic cap_two3;
        logic cs_over;
        logic lo;
    } flags_t;

    localparam int FLAG_W = $bits(flags_t);

endpackage

// File: rtl/bal_sync.sv
module bal_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= '0;
            end
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/bal_evt_cnt.sv
module bal_evt_cnt #(
    parameter int LIMIT = 60,
    parameter int LEAKY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    input  logic hit,
    output logic trip
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q, miss_v;

    if (LEAKY != 0) begin : g_leaky
        assign miss_v = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end else begin : g_clear
        assign miss_v = '0;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LIM_V)) begin
            cnt_d = hit ? cnt_q + 1'b1 : miss_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip = (cnt_q == LIM_V);

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIM_V);

    // R14
    cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(cnt_q));

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/ballast_seq.sv
module ballast_seq
    import ballast_pkg::*;
#(
    parameter int OC_LIMIT    = 60,
    parameter int EOL_LIMIT   = 60,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_on_i,
    input  logic       vcc_off_i,
    input  logic       bus_en_i,
    input  logic       bus_dis_i,
    input  logic       sd_hi_i,
    input  logic       eol_hi_i,
    input  logic       eol_lo_i,
    input  logic       cap_third_i,
    input  logic       cap_half_i,
    input  logic       cap_two3_i,
    input  logic       cs_over_i,
    input  logic       lo_i,
    output logic [5:0] mode_o,
    output logic       osc_en_o,
    output logic       cap_dump_o,
    output logic       vco_dump_o,
    output logic       gate_off_o
);

    typedef struct packed {
        mode_e mode;
        logic  dump;
        logic  pulse;
        logic  lo_prev;
    } seq_t;

    flags_t            raw, fs;
    logic [FLAG_W-1:0] fs_vec;
    seq_t              s_d, s_q;
    logic              tick, cyc_oc, eol_bad, drop, active_q;
    logic              oc_trip, eol_trip, oc_clr, eol_clr;

    assign raw = {vcc_on_i, vcc_off_i, bus_en_i, bus_dis_i, sd_hi_i,
                  eol_hi_i, eol_lo_i, cap_third_i, cap_half_i,
                  cap_two3_i, cs_over_i, lo_i};

    bal_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw),
        .dout (fs_vec)
    );

    assign fs = fs_vec;

    assign tick     = fs.lo & ~s_q.lo_prev;
    assign cyc_oc   = tick & fs.cs_over;
    assign eol_bad  = fs.eol_hi | fs.eol_lo;
    assign drop     = fs.vcc_off | fs.sd_hi | fs.bus_dis;
    assign active_q = (s_q.mode == MD_PREHEAT) || (s_q.mode == MD_IGNITE) ||
                      (s_q.mode == MD_PRERUN)  || (s_q.mode == MD_RUN);
    assign oc_clr   = !((s_q.mode == MD_PREHEAT) || (s_q.mode == MD_RUN));
    assign eol_clr  = (s_q.mode != MD_RUN);

    bal_evt_cnt #(.LIMIT(OC_LIMIT), .LEAKY(1)) u_oc_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (oc_clr),
        .tick (tick),
        .hit  (fs.cs_over),
        .trip (oc_trip)
    );

    bal_evt_cnt #(.LIMIT(EOL_LIMIT), .LEAKY(0)) u_eol_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (eol_clr),
        .tick (tick),
        .hit  (eol_bad),
        .trip (eol_trip)
    );

    always_comb begin
        s_d         = s_q;
        s_d.lo_prev = fs.lo;
        s_d.pulse   = 1'b0;
        unique case (s_q.mode)
            MD_OFF: begin
                if (fs.vcc_on && !fs.vcc_off && fs.bus_en && !fs.bus_dis &&
                    !fs.eol_hi && !fs.sd_hi) begin
                    s_d.mode = MD_PREHEAT;
                    s_d.dump = 1'b0;
                end
            end
            MD_PREHEAT: begin
                if (oc_trip) begin
                    s_d.mode = MD_FAULT;
                    s_d.dump = 1'b0;
                end else if (!s_q.dump && fs.cap_two3) begin
                    s_d.dump = 1'b1;
                end else if (s_q.dump && !fs.cap_third) begin
                    s_d.mode = MD_IGNITE;
                    s_d.dump = 1'b0;
                end
            end
            MD_IGNITE: begin
                s_d.pulse = cyc_oc;
                if (fs.cap_half) s_d.mode = MD_PRERUN;
            end
            MD_PRERUN: begin
                if (cyc_oc)             s_d.mode = MD_FAULT;
                else if (fs.cap_two3)   s_d.mode = MD_RUN;
            end
            MD_RUN: begin
                if (oc_trip || eol_trip) s_d.mode = MD_FAULT;
            end
            MD_FAULT: begin
                if (fs.vcc_off || fs.sd_hi) s_d.mode = MD_OFF;
            end
            default: begin
                s_d.mode = MD_OFF;
                s_d.dump = 1'b0;
            end
        endcase
        if (active_q && drop) begin
            s_d.mode  = MD_OFF;
            s_d.dump  = 1'b0;
            s_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MD_OFF, dump: 1'b0, pulse: 1'b0, lo_prev: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o     = s_q.mode;
    assign osc_en_o   = active_q;
    assign cap_dump_o = (s_q.mode == MD_OFF) || (s_q.mode == MD_FAULT) ||
                        ((s_q.mode == MD_PREHEAT) && s_q.dump);
    assign vco_dump_o = (s_q.mode == MD_OFF) || (s_q.mode == MD_FAULT) ||
                        s_q.pulse;
    assign gate_off_o = (s_q.mode == MD_FAULT);

    // R2
    start_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode == MD_PREHEAT) |->
            $past(fs.vcc_on && fs.bus_en && !fs.eol_hi));

    // R3
    ign_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode == MD_IGNITE) |->
            $past(s_q.mode == MD_PREHEAT && s_q.dump && !fs.cap_third));

    // R4
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.mode == MD_RUN) |-> $past(s_q.mode == MD_PRERUN));

    // R5
    ign_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_IGNITE) |=> (s_q.mode != MD_FAULT));

    // R6
    prerun_oc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_PRERUN && cyc_oc && !drop) |=> (s_q.mode == MD_FAULT));

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_FAULT && !fs.vcc_off && !fs.sd_hi) |=>
            (s_q.mode == MD_FAULT));

    // R10
    drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && drop) |=> (s_q.mode == MD_OFF));

    // R13
    mode_hot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(mode_o) == 1);

endmodule

// File: tb/ballast_seq_test.sv
module ballast_seq_test;

    localparam int CLK_PERIOD = 10;

    localparam int P_VON = 11, P_VOFF = 10, P_BEN = 9, P_BDIS = 8;
    localparam int P_SD  = 7,  P_EHI  = 6,  P_ELO = 5, P_C3   = 4;
    localparam int P_C2  = 3,  P_C23  = 2,  P_CS  = 1, P_LO   = 0;

    localparam logic [5:0] M_OFF = 6'b000001, M_PH  = 6'b000010,
                           M_IGN = 6'b000100, M_PR  = 6'b001000,
                           M_RUN = 6'b010000, M_FLT = 6'b100000;

    // {pins[11:0], expected mode[5:0], expected cap_dump}
    // R13 encoding used in every row
    localparam int NV = 12;
    localparam logic [18:0] VECS [NV] = '{
        {12'b0100_0000_0000, 6'b000001, 1'b1},
        {12'b1010_0100_0000, 6'b000001, 1'b1},
        {12'b1010_0000_0000, 6'b000010, 1'b0},
        {12'b1010_0001_0000, 6'b000010, 1'b0},
        {12'b1010_0001_0100, 6'b000010, 1'b1},
        {12'b1010_0001_0000, 6'b000010, 1'b1},
        {12'b1010_0000_0000, 6'b000100, 1'b0},
        {12'b1010_0001_0000, 6'b000100, 1'b0},
        {12'b1010_0001_1000, 6'b001000, 1'b0},
        {12'b1010_0001_1100, 6'b010000, 1'b0},
        {12'b1011_0000_0000, 6'b000001, 1'b1},
        {12'b1010_0000_0000, 6'b000010, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] pins = '0;
    logic [5:0]  mode_o;
    logic        osc_en_o, cap_dump_o, vco_dump_o, gate_off_o;
    int          total = 0, bad = 0, pulse_cnt = 0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ballast_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .vcc_on_i   (pins[P_VON]),
        .vcc_off_i  (pins[P_VOFF]),
        .bus_en_i   (pins[P_BEN]),
        .bus_dis_i  (pins[P_BDIS]),
        .sd_hi_i    (pins[P_SD]),
        .eol_hi_i   (pins[P_EHI]),
        .eol_lo_i   (pins[P_ELO]),
        .cap_third_i(pins[P_C3]),
        .cap_half_i (pins[P_C2]),
        .cap_two3_i (pins[P_C23]),
        .cs_over_i  (pins[P_CS]),
        .lo_i       (pins[P_LO]),
        .mode_o     (mode_o),
        .osc_en_o   (osc_en_o),
        .cap_dump_o (cap_dump_o),
        .vco_dump_o (vco_dump_o),
        .gate_off_o (gate_off_o)
    );

    always @(negedge clk) begin
        if (vco_dump_o && mode_o == M_IGN) pulse_cnt++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic lo_cycle(input logic cs, input logic elo);
        pins[P_CS]  = cs;
        pins[P_ELO] = elo;
        pins[P_LO]  = 1'b1;
        wait_n(4);
        pins[P_LO]  = 1'b0;
        wait_n(4);
    endtask

    task automatic to_preheat();
        pins = 12'b0100_0000_0000;
        wait_n(6);
        pins = 12'b1010_0000_0000;
        wait_n(6);
    endtask

    task automatic to_ignite();
        to_preheat();
        pins[P_C3] = 1'b1; pins[P_C23] = 1'b1; wait_n(6);
        pins[P_C23] = 1'b0; wait_n(6);
        pins[P_C3] = 1'b0; wait_n(6);
        pins[P_C3] = 1'b1; wait_n(6);
    endtask

    task automatic to_prerun();
        to_ignite();
        pins[P_C2] = 1'b1; wait_n(6);
    endtask

    task automatic to_run();
        to_prerun();
        pins[P_C23] = 1'b1; wait_n(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state, R13 lockout code
        chk("R1 mode",  mode_o, M_OFF);
        chk("R1 osc",   osc_en_o, 0);
        chk("R1 cdump", cap_dump_o, 1);
        chk("R1 vdump", vco_dump_o, 1);
        chk("R1 gate",  gate_off_o, 0);

        // table walk: R2 R3 R4 R10 R11
        for (int i = 0; i < NV; i++) begin
            pins = VECS[i][18:7];
            wait_n(6);
            chk($sformatf("R3 table mode step %0d", i), mode_o, VECS[i][6:1]);
            chk($sformatf("R3 table dump step %0d", i), cap_dump_o, VECS[i][0]);
        end
        chk("R2 osc in preheat", osc_en_o, 1);
        chk("R2 vco released", vco_dump_o, 0);

        // R12 synchronizer latency
        pins = 12'b0100_0000_0000; wait_n(6);
        pins = 12'b1010_0000_0000;
        wait_n(2);
        chk("R12 not yet", mode_o, M_OFF);
        wait_n(1);
        chk("R12 visible", mode_o, M_PH);

        // R5 ignition regulation pulses
        to_ignite();
        pulse_cnt = 0;
        repeat (3) lo_cycle(1'b1, 1'b0);
        lo_cycle(1'b0, 1'b0);
        wait_n(6);
        chk("R5 pulse count", pulse_cnt, 3);
        chk("R5 stays ignition", mode_o, M_IGN);

        // R6 single over-current in pre-run, R14 clean cycle no effect
        to_prerun();
        lo_cycle(1'b0, 1'b0); wait_n(6);
        chk("R14 clean cycle", mode_o, M_PR);
        lo_cycle(1'b1, 1'b0); wait_n(6);
        chk("R6 trip", mode_o, M_FLT);
        chk("R9 gate off", gate_off_o, 1);
        chk("R9 osc off", osc_en_o, 0);
        chk("R9 cap dump", cap_dump_o, 1);
        chk("R9 vco dump", vco_dump_o, 1);
        pins[P_BDIS] = 1'b1; wait_n(6);
        chk("R9 bus ignored", mode_o, M_FLT);
        pins[P_SD] = 1'b1; wait_n(6);
        chk("R9 shutdown exit", mode_o, M_OFF);

        // R7 up/down counter in preheat
        to_preheat();
        repeat (30) begin
            lo_cycle(1'b1, 1'b0);
            lo_cycle(1'b0, 1'b0);
        end
        wait_n(6);
        chk("R7 alternating", mode_o, M_PH);
        repeat (59) lo_cycle(1'b1, 1'b0);
        wait_n(6);
        chk("R7 one below", mode_o, M_PH);
        lo_cycle(1'b1, 1'b0); wait_n(6);
        chk("R7 trip", mode_o, M_FLT);
        pins[P_CS] = 1'b0;
        pins[P_VOFF] = 1'b1; wait_n(6);
        chk("R9 supply exit", mode_o, M_OFF);

        // R8 window ignored outside run
        to_preheat();
        repeat (70) lo_cycle(1'b0, 1'b1);
        wait_n(6);
        chk("R8 ignored in preheat", mode_o, M_PH);

        // R8 persistence in run
        to_run();
        chk("R4 run reached", mode_o, M_RUN);
        repeat (59) lo_cycle(1'b0, 1'b1);
        lo_cycle(1'b0, 1'b0);
        repeat (59) lo_cycle(1'b0, 1'b1);
        wait_n(6);
        chk("R8 interrupted", mode_o, M_RUN);
        lo_cycle(1'b0, 1'b1); wait_n(6);
        chk("R8 trip", mode_o, M_FLT);

        // R10 exit beats advance in the same clock
        to_prerun();
        pins[P_C23] = 1'b1;
        pins[P_VOFF] = 1'b1;
        wait_n(6);
        chk("R10 priority", mode_o, M_OFF);

        // R11 restart
        pins = 12'b1010_0000_0000; wait_n(6);
        chk("R11 restart", mode_o, M_PH);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule